// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address after a translation cache miss. It walks a two-level page table held in memory. A page-directory base input gives the physical address of the current directory. The top ten bits of the virtual address pick a 32-bit directory entry. When that entry describes a 4MB page, the walk ends after that single read. Otherwise the next ten bits pick a 32-bit entry in the page table that the directory entry points to. The low twelve bits pass through untranslated as the byte offset within the 4KB frame.

Each entry carries a frame address and protection flags. The block merges the flags from both levels and checks them against the request, which is marked as a write or a read, and as user or supervisor. The walk then ends in one of two ways. It pulses `done` with a translation ready for the cache fill, or it pulses `fault` with a fault code and the level at which the walk stopped. Memory is reached through a simple read port that has only one read outstanding at a time. Only one walk runs at a time, and `busy` keeps new requests out until the ending pulse.

Top module: `pgwalk`

## Requirements
- R1: One cycle after a request is accepted, `memReq` pulses for one cycle with `memAddr` = `dirBase` + 4 × `reqVaddr[31:22]`. The sum is a full 32-bit add.
- R2: If the directory entry has present bit 0 set and large bit 7 clear, a second one-cycle `memReq` follows with `memAddr` = {dirEntry[31:12], 12'h000} + 4 × `reqVaddr[21:12]`.
- R3: A small-page walk with no fault ends with `done` and `physAddr` = {tableEntry[31:12], `reqVaddr[11:0]`}, with `largePage` = 0.
- R4: A present directory entry with bit 7 set ends the walk after exactly one memory read. If there is no fault, `physAddr` = {dirEntry[31:22], `reqVaddr[21:0]`} and `largePage` = 1.
- R5: An entry with bit 0 clear ends the walk with `fault`, `faultCode` = 2'b01, and `faultLevel` = 1 for the directory or 2 for the table. No further read is issued.
- R6: On `done`, `permWrite` is the AND of bit 1 over the entries read, and `permUser` is the AND of bit 2 over the entries read.
- R7: A write request without effective write permission, or a user request without effective user permission, ends with `fault`, `faultCode` = 2'b10, and `faultLevel` = the level of the last entry read.
- R8: `busy` is high from the cycle after a request is accepted until the cycle in which `done` or `fault` pulses. Requests made while busy are ignored. `done` and `fault` are one-cycle pulses and never occur together.
- R9: After reset, `busy`, `memReq`, `done` and `fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBase | input | 32 | Physical address of the current page directory |
| reqValid | input | 1 | Start a walk (taken only while not busy) |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Request is a write |
| reqUser | input | 1 | Request is made at user privilege |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | 32 | Read address, held for the whole wait |
| memValid | input | 1 | Read data is valid this cycle |
| memData | input | 32 | Entry returned by memory |
| done | output | 1 | Translation ready (pulse) |
| fault | output | 1 | Walk ended in a fault (pulse) |
| faultCode | output | 2 | 01 not present, 10 protection |
| faultLevel | output | 2 | Level at which the walk stopped (1 or 2) |
| physAddr | output | 32 | Translated physical address |
| largePage | output | 1 | Translation is a 4MB page |
| permWrite | output | 1 | Effective write permission |
| permUser | output | 1 | Effective user permission |

## Verification
The bench sweeps hundreds of virtual addresses across three directory bases. One of the bases is unaligned, so a design that splices address bits instead of adding them would read the wrong entry. The table contents come from an arithmetic hash, which yields every outcome: small pages, large pages, absent entries at either level, and protection faults at either level. A design that ORs the flags instead of ANDing them, that reads a second time after a large or absent directory entry, or that reports the wrong level would miss the expected `faultCode`, `faultLevel`, or read count. Extra requests made mid-walk expose a design that restarts or changes its address while busy.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // entry flag bit positions
  localparam int unsigned ENT_P  = 0;
  localparam int unsigned ENT_W  = 1;
  localparam int unsigned ENT_U  = 2;
  localparam int unsigned ENT_LG = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR, ST_DWAIT, ST_TBL, ST_TWAIT
  } walkSt_t;

  typedef enum logic [1:0] {
    FC_NONE   = 2'b00,
    FC_ABSENT = 2'b01,
    FC_PROT   = 2'b10
  } fcode_t;

  typedef struct packed {
    logic       capture;
    logic       useTbl;
    logic       holdDir;
    logic       finOk;
    logic       finLarge;
    logic       finFault;
    fcode_t     code;
    logic [1:0] level;
  } walkCtl_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memValid,
  input  logic     entPresent,
  input  logic     entLarge,
  input  logic     permOk,
  output logic     busy,
  output logic     memReq,
  output walkCtl_t ctl
);
  walkSt_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        nextState   = ST_DIR;
      end
      ST_DIR: nextState = ST_DWAIT;
      ST_DWAIT: if (memValid) begin
        nextState = ST_IDLE;
        if (!entPresent) begin
          ctl.finFault = 1'b1;
          ctl.code     = FC_ABSENT;
          ctl.level    = 2'd1;
        end else if (entLarge) begin
          if (permOk) begin
            ctl.finOk    = 1'b1;
            ctl.finLarge = 1'b1;
          end else begin
            ctl.finFault = 1'b1;
            ctl.code     = FC_PROT;
            ctl.level    = 2'd1;
          end
        end else begin
          ctl.holdDir = 1'b1;
          nextState   = ST_TBL;
        end
      end
      ST_TBL: begin
        ctl.useTbl = 1'b1;
        nextState  = ST_TWAIT;
      end
      ST_TWAIT: begin
        ctl.useTbl = 1'b1;
        if (memValid) begin
          nextState = ST_IDLE;
          if (!entPresent) begin
            ctl.finFault = 1'b1;
            ctl.code     = FC_ABSENT;
            ctl.level    = 2'd2;
          end else if (!permOk) begin
            ctl.finFault = 1'b1;
            ctl.code     = FC_PROT;
            ctl.level    = 2'd2;
          end else begin
            ctl.finOk = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_DIR) || (state == ST_TBL);

  // R8: an accepted request makes the walker busy next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid) |=> busy);
  // R1: each read request lasts a single cycle
  a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  // R4: a present large directory entry ends the walk with no second read
  a_r4_large_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DWAIT && memValid && entPresent && entLarge) |=> (!busy && !memReq));
  // R5: an absent directory entry stops the walk
  a_r5_absent_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DWAIT && memValid && !entPresent) |=> !busy);
endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              entPresent,
  output logic              entLarge,
  output logic              permOk,
  output logic [ADDR_W-1:0] physAddr,
  output logic              largePage,
  output logic              permWrite,
  output logic              permUser,
  output logic              done,
  output logic              fault,
  output fcode_t            faultCode,
  output logic [1:0]        faultLevel
);
  localparam int unsigned LG_W = OFF_W + IDX_W;

  logic [ADDR_W-1:0] vaddrQ, pdeQ;
  logic              wrQ, usrQ;
  logic [IDX_W-1:0]  dirIdx, tblIdx;
  logic [ADDR_W-1:0] dirAddr, tblAddr;
  logic              effW, effU;

  assign dirIdx  = vaddrQ[ADDR_W-1 -: IDX_W];
  assign tblIdx  = vaddrQ[OFF_W +: IDX_W];
  assign dirAddr = dirBase + ADDR_W'({dirIdx, 2'b00});
  assign tblAddr = {pdeQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + ADDR_W'({tblIdx, 2'b00});
  assign memAddr = ctl.useTbl ? tblAddr : dirAddr;

  assign entPresent = memData[ENT_P];
  assign entLarge   = memData[ENT_LG];
  assign effW   = memData[ENT_W] & (ctl.useTbl ? pdeQ[ENT_W] : 1'b1);
  assign effU   = memData[ENT_U] & (ctl.useTbl ? pdeQ[ENT_U] : 1'b1);
  assign permOk = (!wrQ || effW) && (!usrQ || effU);

  logic unusedBits;
  assign unusedBits = ^{memData[ENT_LG-1:ENT_U+1], memData[OFF_W-1:ENT_LG+1],
                        pdeQ[ENT_P], pdeQ[OFF_W-1:ENT_U+1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ     <= '0;
      pdeQ       <= '0;
      wrQ        <= 1'b0;
      usrQ       <= 1'b0;
      physAddr   <= '0;
      largePage  <= 1'b0;
      permWrite  <= 1'b0;
      permUser   <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      faultCode  <= FC_NONE;
      faultLevel <= 2'd0;
    end else begin
      done  <= ctl.finOk;
      fault <= ctl.finFault;
      if (ctl.capture) begin
        vaddrQ <= reqVaddr;
        wrQ    <= reqWrite;
        usrQ   <= reqUser;
      end
      if (ctl.holdDir) pdeQ <= memData;
      if (ctl.finOk) begin
        physAddr   <= ctl.finLarge ? {memData[ADDR_W-1:LG_W], vaddrQ[LG_W-1:0]}
                                   : {memData[ADDR_W-1:OFF_W], vaddrQ[OFF_W-1:0]};
        largePage  <= ctl.finLarge;
        permWrite  <= effW;
        permUser   <= effU;
        faultCode  <= FC_NONE;
        faultLevel <= 2'd0;
      end
      if (ctl.finFault) begin
        faultCode  <= ctl.code;
        faultLevel <= ctl.level;
        largePage  <= 1'b0;
      end
    end
  end

  // R8: a walk has exactly one outcome
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault));
  // R5: the reported level is 1 or 2
  a_r5_level_range: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultLevel == 2'd1 || faultLevel == 2'd2));
  // R2: the table address holds while the second read is outstanding
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.useTbl && $past(ctl.useTbl)) |-> $stable(memAddr));
  // R4: a large-page outcome is never paired with a fault code
  a_r4_large_clean: assert property (@(posedge clk) disable iff (!rstN)
    (done && largePage) |-> (faultCode == FC_NONE));
endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memData,
  output logic              done,
  output logic              fault,
  output logic [1:0]        faultCode,
  output logic [1:0]        faultLevel,
  output logic [ADDR_W-1:0] physAddr,
  output logic              largePage,
  output logic              permWrite,
  output logic              permUser
);
  walkCtl_t ctl;
  logic     entPresent, entLarge, permOk;
  fcode_t   faultCodeE;

  pgwalk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memValid(memValid),
    .entPresent(entPresent), .entLarge(entLarge), .permOk(permOk),
    .busy(busy), .memReq(memReq), .ctl(ctl)
  );

  pgwalk_dp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dirBase(dirBase),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .memData(memData), .memAddr(memAddr), .entPresent(entPresent),
    .entLarge(entLarge), .permOk(permOk), .physAddr(physAddr),
    .largePage(largePage), .permWrite(permWrite), .permUser(permUser),
    .done(done), .fault(fault), .faultCode(faultCodeE), .faultLevel(faultLevel)
  );

  assign faultCode = faultCodeE;
endmodule

// File: tb/test_pgwalk.sv
`timescale 1ns/1ps
module test_pgwalk;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dirBase = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        busy, memReq, done, fault, largePage, permWrite, permUser;
  logic [31:0] memAddr, physAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic [1:0]  faultCode, faultLevel;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int cnt = 0;
  int reqSeen = 0;
  logic [31:0] pendAddr = '0;
  logic [31:0] seenAddr [0:3];
  int nOk = 0, nLarge = 0, nAbs1 = 0, nAbs2 = 0, nProt1 = 0, nProt2 = 0;

  always #10 clk = ~clk;

  pgwalk i_pgwalk (
    .clk(clk), .rstN(rstN), .dirBase(dirBase), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .busy(busy), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .done(done), .fault(fault), .faultCode(faultCode),
    .faultLevel(faultLevel), .physAddr(physAddr), .largePage(largePage),
    .permWrite(permWrite), .permUser(permUser)
  );

  // table contents: an arithmetic hash of the entry address
  function automatic logic [31:0] entryAt(input logic [31:0] a);
    logic [31:0] x;
    x = (a ^ (a >> 13)) * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x[0] = |x[17:15];
    x[1] = x[19];
    x[2] = x[21];
    x[7] = x[23] & x[24];
    return x;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // memory responder: one read outstanding, latency set by the bench
  always @(negedge clk) begin
    memValid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        memValid = 1'b1;
        memData  = entryAt(pendAddr);
      end
    end
    if (memReq) begin
      if (reqSeen < 4) seenAddr[reqSeen] = memAddr;
      reqSeen++;
      pendAddr = memAddr;
      cnt = lat;
    end
  end

  task automatic runWalk(input logic [31:0] va, input bit wr, input bit us,
                         input int latIn, input bit disturb);
    logic [31:0] pde, pte, a0, a1, expPhys;
    int expKind, expLvl, expReads, t;
    bit effW, effU, expLarge;
    a0 = dirBase + {20'd0, va[31:22], 2'b00};
    a1 = '0;
    pde = entryAt(a0);
    expPhys = '0; expLarge = 0; effW = 0; effU = 0; expLvl = 0;
    if (!pde[0]) begin
      expKind = 1; expLvl = 1; expReads = 1;
    end else if (pde[7]) begin
      expReads = 1; expLarge = 1;
      effW = pde[1]; effU = pde[2];
      expPhys = {pde[31:22], va[21:0]};
      expKind = ((wr && !effW) || (us && !effU)) ? 2 : 0;
      if (expKind == 2) expLvl = 1;
    end else begin
      expReads = 2;
      a1 = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      pte = entryAt(a1);
      if (!pte[0]) begin
        expKind = 1; expLvl = 2;
      end else begin
        effW = pde[1] & pte[1]; effU = pde[2] & pte[2];
        expPhys = {pte[31:12], va[11:0]};
        expKind = ((wr && !effW) || (us && !effU)) ? 2 : 0;
        if (expKind == 2) expLvl = 2;
      end
    end

    @(negedge clk);
    lat = latIn; reqSeen = 0;
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqUser = us;
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after accept", {31'd0, busy}, 32'd1);
    if (disturb) begin
      reqVaddr = ~va; reqWrite = ~wr;
    end else begin
      reqValid = 1'b0;
    end
    @(negedge clk);
    reqValid = 1'b0;
    t = 0;
    while (!(done || fault) && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk(!(done && fault), "R8 single outcome", {30'd0, done, fault}, 32'd0);
    chk(busy == 1'b0, "R8 busy low at end", {31'd0, busy}, 32'd0);
    chk(reqSeen == expReads, "R4/R5 read count", reqSeen, expReads);
    chk(seenAddr[0] == a0, "R1 directory address", seenAddr[0], a0);
    if (expReads == 2 && reqSeen >= 2)
      chk(seenAddr[1] == a1, "R2 table address", seenAddr[1], a1);
    if (expKind == 0) begin
      chk(done == 1'b1, "R3 done", {31'd0, done}, 32'd1);
      chk(physAddr == expPhys, expLarge ? "R4 large physAddr" : "R3 physAddr",
          physAddr, expPhys);
      chk(largePage == expLarge, "R4 largePage", {31'd0, largePage}, {31'd0, expLarge});
      chk({permWrite, permUser} == {effW, effU}, "R6 merged permissions",
          {30'd0, permWrite, permUser}, {30'd0, effW, effU});
      nOk++;
      if (expLarge) nLarge++;
    end else begin
      chk(fault == 1'b1, "R5/R7 fault", {31'd0, fault}, 32'd1);
      chk(faultCode == ((expKind == 1) ? 2'b01 : 2'b10),
          (expKind == 1) ? "R5 faultCode" : "R7 faultCode",
          {30'd0, faultCode}, (expKind == 1) ? 32'd1 : 32'd2);
      chk(faultLevel == expLvl[1:0], (expKind == 1) ? "R5 faultLevel" : "R7 faultLevel",
          {30'd0, faultLevel}, expLvl);
      if (expKind == 1 && expLvl == 1) nAbs1++;
      if (expKind == 1 && expLvl == 2) nAbs2++;
      if (expKind == 2 && expLvl == 1) nProt1++;
      if (expKind == 2 && expLvl == 2) nProt2++;
    end
    @(negedge clk);
    chk(!done && !fault && !memReq, "R8 pulse ends, no extra read",
        {29'd0, done, fault, memReq}, 32'd0);
  endtask

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog act=running exp=finished");
    finish();
  end

  initial begin
    logic [31:0] bases [0:2];
    bases[0] = 32'h0001_0000;
    bases[1] = 32'h1234_5FF0;
    bases[2] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    chk(!busy && !memReq && !done && !fault, "R9 reset state",
        {28'd0, busy, memReq, done, fault}, 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !memReq && !done && !fault, "R9 idle after reset",
        {28'd0, busy, memReq, done, fault}, 32'd0);
    for (int b = 0; b < 3; b++) begin
      dirBase = bases[b];
      for (int k = 0; k < 256; k++) begin
        logic [31:0] va;
        va = (k * 32'h9E37_79B9) + (b * 32'h0013_5791);
        runWalk(va, k[0], k[1], 1 + (k % 3), k[2] & k[3]);
      end
    end
    chk(nOk > 0 && nLarge > 0, "R3/R4 outcomes seen", nLarge, 32'd1);
    chk(nAbs1 > 0 && nAbs2 > 0, "R5 both levels seen", nAbs2, 32'd1);
    chk(nProt1 > 0 && nProt2 > 0, "R7 both levels seen", nProt2, 32'd1);
    finish();
  end
endmodule